// File: doc/BRIEF.md
# Early-Addressed Register File with Write Forwarding

This block is the integer register array of a pipelined core, laid out so that its storage is read through a registered address and can therefore map onto block RAM. The first decode stage hands over three operand addresses one cycle ahead of execution. Each of the three read ports returns its operand in the following cycle. A single write port updates the array. When the pipeline stalls, every port re-reads the address it captured on the last cycle that was not stalled, so the operands stay valid however long the stall lasts.

The write port's enable, address and data are also captured in a register. Every read port compares its registered read address against the captured write address. On a match it returns the captured write data instead of the array output. Because of this comparison, no result ever relies on how the RAM behaves when a read and a write hit the same address in the same cycle.

A debug agent can read any register. A request is first held as pending. It is served through read port B on the first cycle with no stall in which decode reports either no valid instruction or an instruction that does not read operand B. One cycle after that cycle, a debug-valid strobe rises together with the data.

Top module: `rf_early_read`

## Requirements
- R1: The data on each read port in cycle n is the content of the register whose address was on that port in cycle n-1. This content includes every write presented in cycles up to and including n-1.
- R2: A write presented with `wrEn` high stores `wrData` at `wrAddr`. Every later read of that address returns this value until the address is written again.
- R3: The read address on a port in cycle n may equal `wrAddr` in cycle n while `wrEn` is high. In that case the port returns the new `wrData` in cycle n+1. This also holds for back-to-back writes to the same register.
- R4: While `stall` is high, every port ignores its address input and re-reads the address captured on the last cycle with `stall` low. Writes made during the stall still appear in the data.
- R5: A write presented with `wrEn` low changes no register, and it is never forwarded.
- R6: A pending debug request is granted in a cycle only when `stall` is low and either `instValid` is low or `usesB` is low. In the cycle after the grant, `dbgValid` is high for exactly one cycle and `dbgData` holds the register at the requested address, including writes up to the grant cycle. In that same cycle, `rdDataB` carries the debug value.
- R7: A debug request stays pending, without being lost, through any number of cycles in which port B is in use or the pipeline is stalled.
- R8: After reset, no debug request is pending, `dbgValid` is low, and all captured read addresses are zero. A stall held from reset makes every port read register 0.
- R9: A `dbgReq` that arrives while a request is already pending is ignored. The pending request keeps its original address and produces exactly one `dbgValid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Pipeline stall; ports re-read their captured addresses |
| instValid | input | 1 | Decode holds a valid instruction this cycle |
| usesB | input | 1 | The decoded instruction reads operand B |
| rdAddrA | input | 6 | Read address, port A |
| rdAddrB | input | 6 | Read address, port B |
| rdAddrC | input | 6 | Read address, port C |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 6 | Write address |
| wrData | input | 64 | Write data |
| dbgReq | input | 1 | Debug read request (one-cycle pulse) |
| dbgAddr | input | 6 | Debug read address, sampled with the request |
| rdDataA | output | 64 | Read data, port A |
| rdDataB | output | 64 | Read data, port B (debug data while dbgValid) |
| rdDataC | output | 64 | Read data, port C |
| dbgValid | output | 1 | Debug data valid strobe |
| dbgData | output | 64 | Debug read data |

## Verification
A wrong captured read or write address shows up on the affected port in the very next cycle, as data from the wrong register or data that misses a write. A reference array compares every port on every cycle, so the first bad operand is flagged at once. A pending-request flag that is stuck or leaks shows up as a `dbgValid` missing, duplicated or placed in a cycle where port B is busy, and it is caught within one cycle of that slot. A fault in the stall hold logic shows up as data that follows the changing address inputs during a stall, at the first stalled cycle.

// File: rtl/rf_pkg.sv
package rf_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic hold;      // reuse captured read addresses
    logic dbgGrant;  // debug read owns port B this cycle
  } rf_strobe_t;
endpackage

// File: rtl/rf_ctrl.sv
module rf_ctrl
  import rf_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall,
  input  logic          instValid,
  input  logic          usesB,
  input  logic          dbgReq,
  input  logic [AW-1:0] dbgAddr,
  output rf_strobe_t    strobe,
  output logic [AW-1:0] dbgAddrQ,
  output logic          dbgPending,
  output logic          dbgValid
);
  logic portBFree;
  logic grant;

  assign portBFree = !instValid || !usesB;
  assign grant     = dbgPending && portBFree && !stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      dbgPending <= 1'b0;
      dbgAddrQ   <= '0;
      dbgValid   <= 1'b0;
    end else begin
      dbgValid <= grant;
      if (dbgPending) begin
        if (grant) dbgPending <= 1'b0;
      end else if (dbgReq) begin
        dbgPending <= 1'b1;
        dbgAddrQ   <= dbgAddr;
      end
    end
  end

  always_comb begin
    strobe.hold     = stall;
    strobe.dbgGrant = grant;
  end
endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
  import rf_pkg::*;
#(
  parameter int NREG    = 64,
  parameter int DW      = 64,
  parameter int NPORT   = 3,
  parameter int DBGPORT = 1,
  localparam int AW     = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  rf_strobe_t                 strobe,
  input  logic [NPORT-1:0][AW-1:0]   rdAddr,
  input  logic [AW-1:0]              dbgAddr,
  input  logic                       wrEn,
  input  logic [AW-1:0]              wrAddr,
  input  logic [DW-1:0]              wrData,
  output logic [NPORT-1:0][DW-1:0]   rdData
);
  logic [DW-1:0] mem [NREG];

  // Array write straight from the port, so a read one edge later sees it
  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  // Captured write for forwarding
  logic          wEnQ;
  logic [AW-1:0] wAddrQ;
  logic [DW-1:0] wDataQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      wEnQ   <= 1'b0;
      wAddrQ <= '0;
      wDataQ <= '0;
    end else begin
      wEnQ   <= wrEn;
      wAddrQ <= wrAddr;
      wDataQ <= wrData;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam bit IS_DBG = (p == DBGPORT);
    logic [AW-1:0] holdQ;
    logic [AW-1:0] idxQ;
    logic [AW-1:0] effAddr;
    logic [DW-1:0] ramQ;

    always_comb begin
      effAddr = strobe.hold ? holdQ : rdAddr[p];
      if (IS_DBG && strobe.dbgGrant) effAddr = dbgAddr;
    end

    // Synchronous array read, no reset so it maps to block RAM
    always_ff @(posedge clk) begin
      ramQ <= mem[effAddr];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        holdQ <= '0;
        idxQ  <= '0;
      end else begin
        if (!strobe.hold) holdQ <= rdAddr[p];
        idxQ <= effAddr;
      end
    end

    assign rdData[p] = (wEnQ && (wAddrQ == idxQ)) ? wDataQ : ramQ;
  end
endmodule

// File: rtl/rf_early_read.sv
module rf_early_read
  import rf_pkg::*;
#(
  parameter int NREG = 64,
  parameter int DW   = 64,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall,
  input  logic          instValid,
  input  logic          usesB,
  input  logic [AW-1:0] rdAddrA,
  input  logic [AW-1:0] rdAddrB,
  input  logic [AW-1:0] rdAddrC,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          dbgReq,
  input  logic [AW-1:0] dbgAddr,
  output logic [DW-1:0] rdDataA,
  output logic [DW-1:0] rdDataB,
  output logic [DW-1:0] rdDataC,
  output logic          dbgValid,
  output logic [DW-1:0] dbgData
);
  rf_strobe_t          strobe;
  logic [AW-1:0]       dbgAddrQ;
  logic                dbgPending;
  logic [2:0][AW-1:0]  rdAddr;
  logic [2:0][DW-1:0]  rdData;

  assign rdAddr = {rdAddrC, rdAddrB, rdAddrA};

  rf_ctrl #(.AW(AW)) i_ctrl (
    .clk(clk), .rst(rst), .stall(stall), .instValid(instValid), .usesB(usesB),
    .dbgReq(dbgReq), .dbgAddr(dbgAddr), .strobe(strobe), .dbgAddrQ(dbgAddrQ),
    .dbgPending(dbgPending), .dbgValid(dbgValid)
  );

  rf_datapath #(.NREG(NREG), .DW(DW), .NPORT(3), .DBGPORT(1)) i_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .rdAddr(rdAddr), .dbgAddr(dbgAddrQ),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdData(rdData)
  );

  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];
  assign rdDataC = rdData[2];
  assign dbgData = rdData[1];
endmodule

// File: rtl/rf_early_read_chk.sv
module rf_early_read_chk #(
  parameter int AW = 6,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          stall,
  input logic          instValid,
  input logic          usesB,
  input logic [AW-1:0] rdAddrA,
  input logic          wrEn,
  input logic [AW-1:0] wrAddr,
  input logic [DW-1:0] wrData,
  input logic [DW-1:0] rdDataA,
  input logic          dbgValid,
  input logic          dbgPending
);
  // R3: same-cycle write and read of one register forwards the new value
  p_forward_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(wrEn) && !$past(stall) && ($past(rdAddrA) == $past(wrAddr)))
      |-> (rdDataA == $past(wrData)));

  // R4: a stalled cycle with no write leaves port A unchanged
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!rst, 2) && $past(stall) && !$past(wrEn))
      |-> $stable(rdDataA));

  // R6: debug data only follows a cycle where port B was free and not stalled
  p_dbg_slot_r6: assert property (@(posedge clk) disable iff (rst)
    dbgValid |-> ($past(!stall) && ($past(!instValid) || $past(!usesB))));

  // R6: the debug strobe never lasts two cycles
  p_dbg_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    dbgValid |=> !dbgValid);

  // R7: a pending request survives a busy or stalled cycle
  p_pend_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (dbgPending && (stall || (instValid && usesB))) |=> dbgPending);
endmodule

bind rf_early_read rf_early_read_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .stall(stall), .instValid(instValid), .usesB(usesB),
  .rdAddrA(rdAddrA), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdDataA(rdDataA), .dbgValid(dbgValid), .dbgPending(dbgPending)
);

// File: tb/test_rf_early_read.sv
module test_rf_early_read;
  localparam int NREG = 64;
  localparam int DW   = 64;
  localparam int AW   = 6;

  logic clk = 1'b0;
  logic rst, stall, instValid, usesB, wrEn, dbgReq;
  logic [AW-1:0] rdAddrA, rdAddrB, rdAddrC, wrAddr, dbgAddr;
  logic [DW-1:0] wrData, rdDataA, rdDataB, rdDataC, dbgData;
  logic dbgValid;

  always #2 clk = ~clk;

  rf_early_read i_rf_early_read (
    .clk(clk), .rst(rst), .stall(stall), .instValid(instValid), .usesB(usesB),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .rdAddrC(rdAddrC),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .dbgReq(dbgReq), .dbgAddr(dbgAddr),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .rdDataC(rdDataC),
    .dbgValid(dbgValid), .dbgData(dbgData)
  );

  int checks = 0;
  int fails  = 0;
  string curReq = "R8";

  // Reference model state
  logic [DW-1:0] refMem [NREG];
  bit            refKnown [NREG];
  logic [AW-1:0] mHold [3];
  bit            mPend;
  logic [AW-1:0] mDbgAddr;
  logic [DW-1:0] expData [3];
  bit            expOk [3];
  bit            expDbgValid;
  int unsigned   seed = 32'h1234_5678;

  function automatic logic [DW-1:0] pat(input int i, input int k);
    return (64'h0123_4567_89AB_CDEF * (i + 1)) ^ (64'(k) << 32) ^ 64'(i);
  endfunction

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  task automatic check(input string what, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %h expected %h", curReq, what, got, exp);
    end
  endtask

  task automatic tick();
    bit grant;
    logic [AW-1:0] in, eff;
    @(posedge clk);
    if (rst) begin
      for (int p = 0; p < 3; p++) begin mHold[p] = '0; expOk[p] = 0; end
      mPend = 0; expDbgValid = 0;
    end else begin
      grant = mPend && !stall && (!instValid || !usesB);
      for (int p = 0; p < 3; p++) begin
        in = (p == 0) ? rdAddrA : (p == 1) ? rdAddrB : rdAddrC;
        eff = stall ? mHold[p] : in;
        if (p == 1 && grant) eff = mDbgAddr;
        if (wrEn && wrAddr == eff) begin expData[p] = wrData; expOk[p] = 1; end
        else begin expData[p] = refMem[eff]; expOk[p] = refKnown[eff]; end
        if (!stall) mHold[p] = in;
      end
      expDbgValid = grant;
      if (mPend) begin
        if (grant) mPend = 0;
      end else if (dbgReq) begin
        mPend = 1; mDbgAddr = dbgAddr;
      end
      if (wrEn) begin refMem[wrAddr] = wrData; refKnown[wrAddr] = 1; end
    end
    @(negedge clk);
    check("dbgValid", 64'(dbgValid), 64'(expDbgValid));
    if (expOk[0]) check("port A", rdDataA, expData[0]);
    if (expOk[1]) check("port B", rdDataB, expData[1]);
    if (expOk[2]) check("port C", rdDataC, expData[2]);
    if (expDbgValid && expOk[1]) check("dbgData", dbgData, expData[1]);
  endtask

  task automatic idle();
    stall = 0; instValid = 0; usesB = 0; wrEn = 0; dbgReq = 0;
  endtask

  initial begin
    rst = 1; idle();
    rdAddrA = '0; rdAddrB = '0; rdAddrC = '0; wrAddr = '0; wrData = '0; dbgAddr = '0;
    for (int i = 0; i < NREG; i++) refKnown[i] = 0;
    @(negedge clk);
    curReq = "R8";
    tick(); tick();
    rst = 0;

    // R2 / R1: fill every register while reading the one written a cycle earlier
    curReq = "R2";
    for (int i = 0; i < NREG; i++) begin
      wrEn = 1; wrAddr = AW'(i); wrData = pat(i, 0);
      rdAddrA = AW'(i - 1); rdAddrB = AW'(i); rdAddrC = AW'(i - 2);
      instValid = 1; usesB = 1;
      tick();
    end
    wrEn = 0;
    curReq = "R1";
    for (int i = 0; i < NREG; i++) begin
      rdAddrA = AW'(i); rdAddrB = AW'(63 - i); rdAddrC = AW'(i + 17);
      tick();
    end

    // R3: back-to-back writes to one register read in the same cycles
    curReq = "R3";
    for (int k = 1; k <= 4; k++) begin
      wrEn = 1; wrAddr = 6'd5; wrData = pat(5, k);
      rdAddrA = 6'd5; rdAddrB = 6'd5; rdAddrC = 6'd5;
      tick();
    end
    wrEn = 0; tick();

    // R5: disabled write with live address and data
    curReq = "R5";
    wrEn = 0; wrAddr = 6'd7; wrData = '1; rdAddrA = 6'd7; rdAddrB = 6'd7; rdAddrC = 6'd7;
    tick(); tick(); tick();

    // R4: multi-cycle stall with changing addresses and a write to a held register
    curReq = "R4";
    rdAddrA = 6'd9; rdAddrB = 6'd10; rdAddrC = 6'd11; tick();
    stall = 1;
    for (int k = 0; k < 5; k++) begin
      rdAddrA = AW'(30 + k); rdAddrB = AW'(40 + k); rdAddrC = AW'(50 + k);
      wrEn = (k == 2); wrAddr = 6'd10; wrData = pat(10, 9);
      tick();
    end
    stall = 0; wrEn = 0; tick(); tick();

    // R7 / R6: request waits on busy port B and on stall, then is served
    curReq = "R7";
    instValid = 1; usesB = 1; dbgReq = 1; dbgAddr = 6'd20; tick();
    dbgReq = 0; tick(); tick(); tick();
    usesB = 0; stall = 1; tick(); tick();
    curReq = "R6";
    stall = 0; wrEn = 1; wrAddr = 6'd20; wrData = pat(20, 3); tick();
    wrEn = 0; tick(); tick();

    // R9: second request while one is pending
    curReq = "R9";
    instValid = 1; usesB = 1; dbgReq = 1; dbgAddr = 6'd33; tick();
    dbgAddr = 6'd44; tick();
    dbgReq = 0; tick(); tick();
    instValid = 0; tick(); tick(); tick();

    // R8: reset while stalled, then hold the stall: every port reads register 0
    curReq = "R8";
    stall = 1; rst = 1; tick(); tick();
    rst = 0; rdAddrA = 6'd5; rdAddrB = 6'd6; rdAddrC = 6'd7;
    tick(); tick();
    stall = 0;

    // R1: long mixed sweep with forced address collisions
    curReq = "R1";
    for (int n = 0; n < 3000; n++) begin
      stall     = (rnd() % 4) == 0;
      instValid = rnd() % 2;
      usesB     = rnd() % 2;
      dbgReq    = (rnd() % 6) == 0;
      dbgAddr   = AW'(rnd());
      wrEn      = rnd() % 2;
      wrAddr    = AW'(rnd() % 8);
      wrData    = {32'(rnd()), 32'(rnd())};
      rdAddrA   = AW'(rnd() % 8);
      rdAddrB   = AW'(rnd() % 16);
      rdAddrC   = AW'(rnd());
      tick();
    end
    idle(); tick(); tick();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule